// File: doc/BRIEF.md
# Legacy Bus Interrupt Aggregator

This block collects a set of legacy peripheral interrupt lines, 18 by default, and presents them to a parent interrupt controller as a single active-high level interrupt. Software reaches it through five 32-bit word registers:

- a control word, which turns the whole block on and chooses level or edge capture;
- a per-line enable mask;
- a read-only status word;
- a write-one-to-clear word;
- a per-line polarity word.

Each input line first has its polarity bit applied, which gives the line's "active" value. The status bit is then captured from that active value. In level mode the status bit follows the active value. In edge mode the status bit records the inactive-to-active transition and keeps it until software clears it. A line is pending when both its status bit and its enable bit are set. The cascade output is high while the block is enabled and at least one line is pending.

Software handles the interrupt in a fixed order. It reads the enable and status words and ANDs them to find the pending lines. It services each pending line and then writes that line's bit to the clear word. To change one line's enable, it reads the enable word, modifies the bit and writes the whole word back. Reads are registered: read data appears one clock after the read strobe.

Top module: `irq_agg_top`

## Requirements
- R1: After reset the control, enable, status and polarity registers are 0, and `irq_out` is low.
- R2: The byte-address field `bus_addr[4:2]` selects the register. The values are 0 for control (0x00), 1 for enable (0x04), 2 for status (0x08), 3 for clear (0x0C) and 4 for polarity (0x10). `bus_addr[1:0]` is ignored. Reads of 0x14, 0x18 and 0x1C return 0. `bus_rdata` is valid on the clock edge after `bus_rd`.
- R3: In the control word, bit 31 is the global enable and bit 30 selects edge capture (1) or level capture (0). The other control bits read as 0.
- R4: In the enable, status, clear and polarity words, bits 31 down to NUM_LINES read as 0 and ignore writes. Writes to the status word have no effect. The clear word reads as 0.
- R5: A polarity bit of 1 makes its line active when high. A polarity bit of 0 makes it active when low.
- R6: In level mode with the block enabled, each status bit equals its line's active value from one clock earlier. A clear has no lasting effect while the line stays active.
- R7: In edge mode with the block enabled, a status bit is set by an inactive-to-active transition of its line and keeps its value until a 1 is written to its bit of the clear word. Clear bits written as 0 leave their status bits unchanged.
- R8: In edge mode, a new transition and a clear of the same bit in the same cycle leave that status bit set.
- R9: One clock after the status and enable registers change, `irq_out` is high exactly when the block is enabled and some line has both its status bit and its enable bit set.
- R10: While the global enable is 0, the block captures no new status, status bits change only through clears, and `irq_out` is low from the next clock.
- R11: A write to the enable word replaces all of its bits at once, and each enable bit masks only its own line. Writes to other registers leave the enable word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_rd | input | 1 | Read strobe; data is returned on the next clock |
| bus_addr | input | 5 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| line_in | input | NUM_LINES | Raw interrupt lines from the peripherals |
| irq_out | output | 1 | Registered level interrupt to the parent controller |

## Verification
Some properties are checked by assertions on every cycle:

- In edge mode a set status bit cannot fall without a clear.
- In level mode a status bit equals the previous cycle's active value.
- While the block is disabled, status only changes through clears and the output stays low.
- Unmapped reads return zero, and the enable word changes only when it is written.

Other behaviours can only be shown by the bench's sweeps. These cover each line in turn under both polarities and both capture modes, enable masking for every pairing of enabled line and firing line, set-over-clear in the same cycle, the truncation of upper bits, and the read-back value of each register.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int DATA_W   = 32;
  localparam int ADDR_W   = 5;
  localparam int IDX_LSB  = 2;
  localparam int IDX_W    = ADDR_W - IDX_LSB;

  localparam logic [IDX_W-1:0] SEL_CTL = 3'd0;
  localparam logic [IDX_W-1:0] SEL_ENA = 3'd1;
  localparam logic [IDX_W-1:0] SEL_STS = 3'd2;
  localparam logic [IDX_W-1:0] SEL_CLR = 3'd3;
  localparam logic [IDX_W-1:0] SEL_POL = 3'd4;

  localparam int CTL_ON_BIT   = 31;
  localparam int CTL_EDGE_BIT = 30;
endpackage

// File: rtl/irq_agg_regs.sv
module irq_agg_regs
  import irq_agg_pkg::*;
#(
  parameter int NUM_LINES = 18
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic                 rd_en,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [DATA_W-1:0]    wdata,
  input  logic [NUM_LINES-1:0] status,
  output logic                 ctl_on,
  output logic                 ctl_edge,
  output logic [NUM_LINES-1:0] ena,
  output logic [NUM_LINES-1:0] pol,
  output logic [NUM_LINES-1:0] clr,
  output logic [DATA_W-1:0]    rdata
);
  logic [IDX_W-1:0]  sel;
  logic [DATA_W-1:0] rd_word;
  logic              unused_ok;

  assign sel       = addr[ADDR_W-1:IDX_LSB];
  assign unused_ok = ^{wdata, addr[IDX_LSB-1:0]};

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_on   <= 1'b0;
      ctl_edge <= 1'b0;
      ena      <= '0;
      pol      <= '0;
    end else if (wr_en) begin
      case (sel)
        SEL_CTL: begin
          ctl_on   <= wdata[CTL_ON_BIT];
          ctl_edge <= wdata[CTL_EDGE_BIT];
        end
        SEL_ENA: ena <= wdata[NUM_LINES-1:0];
        SEL_POL: pol <= wdata[NUM_LINES-1:0];
        default: ;
      endcase
    end
  end

  // Clear strobes go straight to the capture stage in the write cycle
  always_comb begin
    clr = '0;
    if (wr_en && sel == SEL_CLR) clr = wdata[NUM_LINES-1:0];
  end

  always_comb begin
    rd_word = '0;
    case (sel)
      SEL_CTL: begin
        rd_word[CTL_ON_BIT]   = ctl_on;
        rd_word[CTL_EDGE_BIT] = ctl_edge;
      end
      SEL_ENA: rd_word[NUM_LINES-1:0] = ena;
      SEL_STS: rd_word[NUM_LINES-1:0] = status;
      SEL_POL: rd_word[NUM_LINES-1:0] = pol;
      default: rd_word = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= rd_word;
  end

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rd_en && sel > SEL_POL) |=> rdata == '0); // R2

  AST_ENA_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && sel == SEL_ENA) |=> $stable(ena)); // R11
endmodule

// File: rtl/irq_agg_capture.sv
module irq_agg_capture #(
  parameter int NUM_LINES = 18
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 ctl_on,
  input  logic                 ctl_edge,
  input  logic [NUM_LINES-1:0] pol,
  input  logic [NUM_LINES-1:0] lines,
  input  logic [NUM_LINES-1:0] clr,
  output logic [NUM_LINES-1:0] status
);
  logic [NUM_LINES-1:0] active;
  logic [NUM_LINES-1:0] prev_active;

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    logic rise;

    assign active[i] = pol[i] ? lines[i] : ~lines[i];
    assign rise      = active[i] & ~prev_active[i];

    always_ff @(posedge clk) begin
      if (rst) begin
        prev_active[i] <= 1'b0;
        status[i]      <= 1'b0;
      end else begin
        prev_active[i] <= active[i];
        if (!ctl_on)       status[i] <= status[i] & ~clr[i];
        else if (ctl_edge) status[i] <= (status[i] & ~clr[i]) | rise;
        else               status[i] <= active[i];
      end
    end

    AST_EDGE_HOLD: assert property (@(posedge clk) disable iff (rst)
      (ctl_edge && status[i] && !clr[i]) |=> status[i]); // R7

    AST_LEVEL_FOLLOW: assert property (@(posedge clk) disable iff (rst)
      (ctl_on && !ctl_edge) |=> status[i] == $past(active[i])); // R6

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
      (!ctl_on && !clr[i]) |=> $stable(status[i])); // R10
  end
endmodule

// File: rtl/irq_agg_out.sv
module irq_agg_out #(
  parameter int NUM_LINES = 18
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 ctl_on,
  input  logic [NUM_LINES-1:0] status,
  input  logic [NUM_LINES-1:0] ena,
  output logic                 irq_out
);
  always_ff @(posedge clk) begin
    if (rst) irq_out <= 1'b0;
    else     irq_out <= ctl_on & (|(status & ena));
  end

  AST_OFF_QUIET: assert property (@(posedge clk) disable iff (rst)
    !ctl_on |=> !irq_out); // R10
endmodule

// File: rtl/irq_agg_top.sv
module irq_agg_top
  import irq_agg_pkg::*;
#(
  parameter int NUM_LINES = 18
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 bus_wr,
  input  logic                 bus_rd,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [DATA_W-1:0]    bus_wdata,
  output logic [DATA_W-1:0]    bus_rdata,
  input  logic [NUM_LINES-1:0] line_in,
  output logic                 irq_out
);
  logic                 ctl_on;
  logic                 ctl_edge;
  logic [NUM_LINES-1:0] ena;
  logic [NUM_LINES-1:0] pol;
  logic [NUM_LINES-1:0] clr;
  logic [NUM_LINES-1:0] status;

  irq_agg_regs #(.NUM_LINES(NUM_LINES)) u_regs (
    .clk(clk), .rst(rst), .wr_en(bus_wr), .rd_en(bus_rd), .addr(bus_addr),
    .wdata(bus_wdata), .status(status), .ctl_on(ctl_on), .ctl_edge(ctl_edge),
    .ena(ena), .pol(pol), .clr(clr), .rdata(bus_rdata)
  );

  irq_agg_capture #(.NUM_LINES(NUM_LINES)) u_capture (
    .clk(clk), .rst(rst), .ctl_on(ctl_on), .ctl_edge(ctl_edge), .pol(pol),
    .lines(line_in), .clr(clr), .status(status)
  );

  irq_agg_out #(.NUM_LINES(NUM_LINES)) u_out (
    .clk(clk), .rst(rst), .ctl_on(ctl_on), .status(status), .ena(ena),
    .irq_out(irq_out)
  );
endmodule

// File: tb/test_irq_agg_top.sv
module test_irq_agg_top;
  localparam int N = 18;
  localparam logic [31:0] ALL = (32'h1 << N) - 1;
  localparam logic [4:0] A_CTL = 5'h00, A_ENA = 5'h04, A_STS = 5'h08,
                         A_CLR = 5'h0C, A_POL = 5'h10;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          bus_wr = 1'b0, bus_rd = 1'b0;
  logic [4:0]    bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [N-1:0]  line_in = '0;
  logic          irq_out;
  int            checks = 0, errors = 0;
  logic          done = 1'b0;

  always #2 clk = ~clk;

  irq_agg_top #(.NUM_LINES(N)) i_irq_agg_top (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .line_in(line_in), .irq_out(irq_out)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [31:0] exp;
    idle(3);
    rst = 1'b0;
    idle(1);

    // R1: reset values
    rd(A_CTL, d); chk("R1 ctl", d, 0);
    rd(A_ENA, d); chk("R1 ena", d, 0);
    rd(A_STS, d); chk("R1 sts", d, 0);
    rd(A_POL, d); chk("R1 pol", d, 0);
    chk("R1 irq", {31'b0, irq_out}, 0);

    // R3 / R4: field widths, R2 unmapped offsets and ignored low address bits
    wr(A_CTL, 32'hFFFF_FFFF); rd(A_CTL, d); chk("R3 ctl bits", d, 32'hC000_0000);
    wr(A_CTL, 32'h0);
    wr(A_ENA, 32'hFFFF_FFFF); rd(A_ENA, d); chk("R4 ena width", d, ALL);
    wr(A_POL | 5'h3, 32'hFFFF_FFFF); rd(A_POL | 5'h2, d); chk("R2 low addr bits", d, ALL);
    rd(A_CLR, d); chk("R4 clr reads 0", d, 0);
    wr(A_STS, 32'hFFFF_FFFF); rd(A_STS, d); chk("R4 sts read-only", d, 0);
    rd(A_ENA, d); chk("R11 ena untouched", d, ALL);
    for (int a = 5; a < 8; a++) begin
      wr(5'(a * 4), 32'hFFFF_FFFF);
      rd(5'(a * 4), d); chk("R2 unmapped", d, 0);
    end

    // R6 / R5 / R9: level mode, active-high, every line
    wr(A_CTL, 32'h8000_0000);
    for (int i = 0; i < N; i++) begin
      line_in = N'(1) << i; idle(2);
      chk("R9 irq level hi", {31'b0, irq_out}, 1);
      rd(A_STS, d); chk("R6 sts level hi", d, 32'h1 << i);
    end
    line_in = '0; idle(2);
    chk("R6 irq drops", {31'b0, irq_out}, 0);

    // R5: active-low polarity sweep
    wr(A_POL, 32'h0);
    for (int i = 0; i < N; i++) begin
      line_in = ~(N'(1) << i); idle(2);
      rd(A_STS, d); chk("R5 active low", d, 32'h1 << i);
    end
    line_in = '1; idle(2);
    rd(A_STS, d); chk("R5 all inactive", d, 0);
    chk("R5 irq low", {31'b0, irq_out}, 0);

    // R6: clear has no lasting effect in level mode
    line_in = '0; idle(1);
    wr(A_CLR, ALL); idle(1);
    rd(A_STS, d); chk("R6 clear no effect", d, ALL);

    // R11 / R9: masking sweep, every (enabled, firing) pair
    wr(A_POL, ALL); line_in = '0; idle(2);
    for (int j = 0; j < N; j++) begin
      wr(A_ENA, 32'h1 << j);
      for (int i = 0; i < N; i++) begin
        line_in = N'(1) << i; idle(2);
        chk("R11 mask pair", {31'b0, irq_out}, (i == j) ? 1 : 0);
      end
      line_in = '0;
    end
    idle(2);

    // R7: edge mode, pulses latched, W1C per bit
    wr(A_ENA, ALL);
    wr(A_CTL, 32'hC000_0000); idle(1);
    exp = 0;
    for (int i = 0; i < N; i += 3) begin
      line_in = N'(1) << i; idle(1);
      line_in = '0; idle(1);
      exp |= 32'h1 << i;
    end
    idle(1);
    rd(A_STS, d); chk("R7 edges held", d, exp);
    chk("R9 irq edge", {31'b0, irq_out}, 1);
    for (int k = 0; k < N; k += 3) begin
      wr(A_CLR, 32'h1 << k);
      exp &= ~(32'h1 << k);
      rd(A_STS, d); chk("R7 w1c single", d, exp);
    end
    idle(1);
    chk("R9 irq cleared", {31'b0, irq_out}, 0);

    // R7: a held-active line does not re-set after clear
    line_in = N'(1) << 5; idle(2);
    wr(A_CLR, 32'h1 << 5); idle(1);
    rd(A_STS, d); chk("R7 no retrigger", d, 0);
    line_in = '0; idle(1);

    // R8: same-cycle edge and clear, set wins
    line_in = N'(1) << 9;
    wr(A_CLR, 32'h1 << 9);
    rd(A_STS, d); chk("R8 set wins", d, 32'h1 << 9);
    line_in = '0; idle(1);

    // R10: disabled block captures nothing, output low, clears apply
    wr(A_CTL, 32'h0); idle(1);
    chk("R10 irq off", {31'b0, irq_out}, 0);
    line_in = N'(1) << 2; idle(1); line_in = '0; idle(1);
    rd(A_STS, d); chk("R10 no capture", d, 32'h1 << 9);
    wr(A_CLR, ALL);
    rd(A_STS, d); chk("R10 clear while off", d, 0);
    wr(A_CTL, 32'hC000_0000); idle(2);
    chk("R10 re-enabled quiet", {31'b0, irq_out}, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule